// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a small last-in, first-out record of finished transmissions. Each time the transmit engine reports a completion, the block pushes a one-byte status entry. The entry carries a valid marker, the interrupt request that came with the frame, and the jabber, underrun and collision-limit error flags. The host always sees the most recent entry on a combinational read port. A host write removes that entry. When a completion arrives and every slot is already taken, it is discarded, and the entry on top is marked with an overflow flag.

The block also gates the transmitter. A jabber or underrun completion sets a lock that holds the transmit gate low, and a later enable command does not release it. Only a transmit reset releases the lock. That reset also empties the stack, clears the completion event and leaves the gate closed until the next enable command. The completion event output rises when an entry that needs attention is stored. It falls when the host drains the stack.

Top module: `txstat_stack`

## Requirements
- R1: An entry uses this bit layout: bit 7 = 1 (valid), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = collision limit, bit 2 = overflow (0 when pushed), and bits 1..0 = 0.
- R2: `status_rdata` shows the most recently stored entry that has not been removed, starting in the cycle after the completion. Removals show the older entries in reverse order of arrival.
- R3: A `host_wr` pulse removes the top entry. A `host_wr` pulse on an empty stack changes nothing.
- R4: When the stack is empty, `status_rdata` reads 0x00.
- R5: The stack holds DEPTH entries (4 by default). A completion that arrives while the stack is full is dropped, the top entry gains bit 2, and the stack depth stays the same.
- R6: A completion and a `host_wr` pulse in the same cycle replace the top entry with the new one and keep the depth the same. This also applies when the stack is full, and then no overflow is flagged. On an empty stack, the pair simply stores the new entry.
- R7: `txdone_evt` goes to 1 in the cycle after an entry is stored with bit 6, 5, 4 or 3 set. It returns to 0 after the removal that leaves the stack empty. Entries with none of these bits set, and dropped completions, never raise it.
- R8: A completion with jabber or underrun set, whether it is stored or dropped, drives `tx_gate` to 0 from the next cycle. `tx_gate` stays 0 even after `tx_enable_cmd`, until `tx_reset` arrives.
- R9: `tx_reset` empties the stack, clears `txdone_evt` and the error lock, and closes `tx_gate`. It takes priority over any completion, write or enable command in the same cycle. `tx_gate` reopens in the cycle after a later `tx_enable_cmd`.
- R10: While `rst_n` is low, the stack is empty, `status_rdata` is 0x00, and both `txdone_evt` and `tx_gate` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_valid | input | 1 | One-cycle completion report from the transmit engine |
| cmpl_intreq | input | 1 | Interrupt was requested for this frame |
| cmpl_jabber | input | 1 | Jabber error on this frame |
| cmpl_underrun | input | 1 | Underrun error on this frame |
| cmpl_maxcoll | input | 1 | Collision limit reached on this frame |
| host_wr | input | 1 | Host write to the status port; removes the top entry |
| status_rdata | output | 8 | Top entry, or 0x00 when the stack is empty |
| tx_reset | input | 1 | Transmit reset command |
| tx_enable_cmd | input | 1 | Transmit enable command |
| txdone_evt | output | 1 | Completion event to the interrupt logic |
| tx_gate | output | 1 | Transmitter enable gate |

## Verification
The transmit engine and the host can hit the stack in the same cycle: a completion can arrive on the same edge as a host write. The bench provokes this on a full stack and on an empty one. On a full stack the correct result is a replaced top entry with no overflow flag; on an empty one it is a plain store. A further test drains the stack afterwards, and the order of the entries that come out shows that only the top slot changed. A second collision is a fatal completion arriving on the same edge as a transmit reset; the bench checks that the reset wins and that the lock does not remain.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

  localparam int ENTRY_W = 8;
  localparam int B_DONE  = 7;
  localparam int B_IRQ   = 6;
  localparam int B_JAB   = 5;
  localparam int B_UND   = 4;
  localparam int B_MCOL  = 3;
  localparam int B_OVF   = 2;

  typedef logic [ENTRY_W-1:0] entry_t;

  function automatic entry_t build_entry(logic irq, logic jab, logic und, logic mcol);
    entry_t e;
    e         = '0;
    e[B_DONE] = 1'b1;
    e[B_IRQ]  = irq;
    e[B_JAB]  = jab;
    e[B_UND]  = und;
    e[B_MCOL] = mcol;
    return e;
  endfunction

  function automatic entry_t with_overflow(entry_t e);
    entry_t r;
    r        = e;
    r[B_OVF] = 1'b1;
    return r;
  endfunction

  function automatic logic wants_event(entry_t e);
    return e[B_IRQ] | e[B_JAB] | e[B_UND] | e[B_MCOL];
  endfunction

  function automatic logic is_fatal(logic jab, logic und);
    return jab | und;
  endfunction

endpackage

// File: rtl/txstat_lifo.sv
module txstat_lifo
  import txstat_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  input  entry_t        push_data,
  output entry_t        top_data,
  output logic [LW-1:0] level,
  output logic          push_acc,
  output logic          pop_acc,
  output logic          drop_evt,
  output logic          drains
);

  logic [LW-1:0]    level_q;
  logic [LW-1:0]    top_pos;
  logic [LW-1:0]    wr_pos;
  logic             empty;
  logic             full;
  logic [DEPTH-1:0] slot_we;
  logic [DEPTH-1:0] slot_ovf;
  entry_t           slots [DEPTH];

  assign empty    = (level_q == '0);
  assign full     = (level_q == LW'(DEPTH));
  assign top_pos  = level_q - 1'b1;
  assign pop_acc  = pop_req && !empty && !flush;
  assign push_acc = push_req && !flush && (!full || pop_acc);
  assign drop_evt = push_req && !flush && full && !pop_acc;
  assign drains   = pop_acc && !push_acc && (level_q == LW'(1));
  assign wr_pos   = pop_acc ? top_pos : level_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_we[g]  = push_acc && (wr_pos == LW'(g));
    assign slot_ovf[g] = drop_evt && (top_pos == LW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (slot_we[i])       slots[i] <= push_data;
        else if (slot_ovf[i]) slots[i] <= with_overflow(slots[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   level_q <= '0;
    else if (flush)               level_q <= '0;
    else if (push_acc && !pop_acc) level_q <= level_q + 1'b1;
    else if (pop_acc && !push_acc) level_q <= level_q - 1'b1;
  end

  assign top_data = empty ? '0 : slots[top_pos[IW-1:0]];
  assign level    = level_q;

endmodule

// File: rtl/txstat_evt.sv
module txstat_evt
  import txstat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush,
  input  logic   push_acc,
  input  entry_t push_data,
  input  logic   drains,
  output logic   evt
);

  logic evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                evt_q <= 1'b0;
    else if (flush)                            evt_q <= 1'b0;
    else if (push_acc && wants_event(push_data)) evt_q <= 1'b1;
    else if (drains)                           evt_q <= 1'b0;
  end

  assign evt = evt_q;

endmodule

// File: rtl/txstat_gate.sv
module txstat_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic fault,
  input  logic enable_cmd,
  output logic gate
);

  logic lock_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= 1'b0;
    else if (flush) lock_q <= 1'b0;
    else if (fault) lock_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en_q <= 1'b0;
    else if (flush)      en_q <= 1'b0;
    else if (enable_cmd) en_q <= 1'b1;
  end

  assign gate = en_q && !lock_q;

endmodule

// File: rtl/txstat_stack.sv
module txstat_stack
  import txstat_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmpl_valid,
  input  logic       cmpl_intreq,
  input  logic       cmpl_jabber,
  input  logic       cmpl_underrun,
  input  logic       cmpl_maxcoll,
  input  logic       host_wr,
  output logic [7:0] status_rdata,
  input  logic       tx_reset,
  input  logic       tx_enable_cmd,
  output logic       txdone_evt,
  output logic       tx_gate
);

  entry_t        new_entry;
  entry_t        top_entry;
  logic [LW-1:0] level;
  logic          push_acc;
  logic          pop_acc;
  logic          drop_evt;
  logic          drains;
  logic          fault_seen;

  assign new_entry  = build_entry(cmpl_intreq, cmpl_jabber, cmpl_underrun, cmpl_maxcoll);
  assign fault_seen = cmpl_valid && !tx_reset && is_fatal(cmpl_jabber, cmpl_underrun);

  txstat_lifo #(.DEPTH(DEPTH)) u_lifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_reset),
    .push_req  (cmpl_valid),
    .pop_req   (host_wr),
    .push_data (new_entry),
    .top_data  (top_entry),
    .level     (level),
    .push_acc  (push_acc),
    .pop_acc   (pop_acc),
    .drop_evt  (drop_evt),
    .drains    (drains)
  );

  txstat_evt u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_reset),
    .push_acc  (push_acc),
    .push_data (new_entry),
    .drains    (drains),
    .evt       (txdone_evt)
  );

  txstat_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (tx_reset),
    .fault      (fault_seen),
    .enable_cmd (tx_enable_cmd),
    .gate       (tx_gate)
  );

  assign status_rdata = top_entry;

endmodule

// File: rtl/txstat_stack_chk.sv
module txstat_stack_chk #(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmpl_valid,
  input logic          cmpl_intreq,
  input logic          cmpl_jabber,
  input logic          cmpl_underrun,
  input logic          host_wr,
  input logic          tx_reset,
  input logic [7:0]    status_rdata,
  input logic          txdone_evt,
  input logic          tx_gate,
  input logic [LW-1:0] level,
  input logic          push_acc,
  input logic          pop_acc,
  input logic          drop_evt
);

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |=> status_rdata[7] && status_rdata[6] == $past(cmpl_intreq)
                 && status_rdata[5] == $past(cmpl_jabber)
                 && status_rdata[4] == $past(cmpl_underrun)
                 && status_rdata[1:0] == 2'b00); // R1

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (status_rdata == 8'h00)); // R4

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && host_wr && !cmpl_valid && !tx_reset) |=> (level == '0)); // R3

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R5

  AST_OVF_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> status_rdata[2] && level == $past(level)); // R5

  AST_SWAP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && pop_acc) |=> level == $past(level)); // R6

  AST_EVT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(1) && pop_acc && !push_acc) |=> !txdone_evt); // R7

  AST_LOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && (cmpl_jabber || cmpl_underrun) && !tx_reset) |=> !tx_gate); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> level == '0 && !txdone_evt && !tx_gate && status_rdata == 8'h00); // R9

endmodule

bind txstat_stack txstat_stack_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmpl_valid    (cmpl_valid),
  .cmpl_intreq   (cmpl_intreq),
  .cmpl_jabber   (cmpl_jabber),
  .cmpl_underrun (cmpl_underrun),
  .host_wr       (host_wr),
  .tx_reset      (tx_reset),
  .status_rdata  (status_rdata),
  .txdone_evt    (txdone_evt),
  .tx_gate       (tx_gate),
  .level         (level),
  .push_acc      (push_acc),
  .pop_acc       (pop_acc),
  .drop_evt      (drop_evt)
);

// File: tb/txstat_stack_test.sv
module txstat_stack_test;

  typedef struct packed {
    bit       v, ir, jb, un, mc, wr, rs, en;
    bit [7:0] rd;
    bit       ev, gt;
    bit [3:0] rq;
  } vec_t;

  localparam int NV = 32;
  // columns: valid irq jab und mcol wr txrst txen | rdata evt gate | requirement
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00,1'b0,1'b1, 4'd9}, // R9 enable
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80,1'b0,1'b1, 4'd1}, // R1 plain
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hC0,1'b1,1'b1, 4'd7}, // R7 irq
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h88,1'b1,1'b1, 4'd2}, // R2
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'hC0,1'b1,1'b1, 4'd3}, // R3 pop
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hC8,1'b1,1'b1, 4'd1}, // R1
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80,1'b1,1'b1, 4'd2}, // R2 full
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h84,1'b1,1'b1, 4'd5}, // R5 drop
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h84,1'b1,1'b1, 4'd5}, // R5 drop
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h80,1'b1,1'b1, 4'd6}, // R6 swap full
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'hC8,1'b1,1'b1, 4'd3}, // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'hC0,1'b1,1'b1, 4'd3}, // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h80,1'b1,1'b1, 4'd3}, // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,1'b0,1'b1, 4'd7}, // R7 drain
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,1'b0,1'b1, 4'd3}, // R3 empty pop
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80,1'b0,1'b1, 4'd7}, // R7 no flags
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,1'b0,1'b1, 4'd4}, // R4
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hA0,1'b1,1'b0, 4'd8}, // R8 jabber
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hA0,1'b1,1'b0, 4'd8}, // R8 stays shut
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00,1'b0,1'b0, 4'd9}, // R9
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00,1'b0,1'b1, 4'd9}, // R9
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h90,1'b1,1'b0, 4'd8}, // R8 underrun
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'h00,1'b0,1'b0, 4'd9}, // R9 priority
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00,1'b0,1'b1, 4'd9}, // R9
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80,1'b0,1'b1, 4'd5}, // R5 fill
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80,1'b0,1'b1, 4'd5},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80,1'b0,1'b1, 4'd5},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h80,1'b0,1'b1, 4'd5},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h84,1'b0,1'b0, 4'd8}, // R8 dropped jabber
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00,1'b0,1'b0, 4'd9}, // R9
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h80,1'b0,1'b0, 4'd6}, // R6 empty pair
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00,1'b0,1'b0, 4'd3}  // R3
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmpl_valid = 1'b0, cmpl_intreq = 1'b0, cmpl_jabber = 1'b0;
  logic       cmpl_underrun = 1'b0, cmpl_maxcoll = 1'b0;
  logic       host_wr = 1'b0, tx_reset = 1'b0, tx_enable_cmd = 1'b0;
  logic [7:0] status_rdata;
  logic       txdone_evt, tx_gate;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  txstat_stack uut (
    .clk (clk), .rst_n (rst_n),
    .cmpl_valid (cmpl_valid), .cmpl_intreq (cmpl_intreq), .cmpl_jabber (cmpl_jabber),
    .cmpl_underrun (cmpl_underrun), .cmpl_maxcoll (cmpl_maxcoll),
    .host_wr (host_wr), .status_rdata (status_rdata),
    .tx_reset (tx_reset), .tx_enable_cmd (tx_enable_cmd),
    .txdone_evt (txdone_evt), .tx_gate (tx_gate)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual rdata/evt/gate=%h/%b/%b expected=%h/%b/%b",
               tag, act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input vec_t t);
    {cmpl_valid, cmpl_intreq, cmpl_jabber, cmpl_underrun, cmpl_maxcoll,
     host_wr, tx_reset, tx_enable_cmd} = {t.v, t.ir, t.jb, t.un, t.mc, t.wr, t.rs, t.en};
  endtask

  task automatic idle();
    {cmpl_valid, cmpl_intreq, cmpl_jabber, cmpl_underrun, cmpl_maxcoll,
     host_wr, tx_reset, tx_enable_cmd} = '0;
  endtask

  task automatic push(input logic ir, input logic mc);
    cmpl_valid = 1'b1; cmpl_intreq = ir; cmpl_maxcoll = mc;
    @(negedge clk);
    idle();
  endtask

  task automatic pop_check(input logic [7:0] exp);
    host_wr = 1'b1;
    @(negedge clk);
    idle();
    check("R2 lifo order", {status_rdata, 2'b00}, {exp, 2'b00});
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 in reset", {status_rdata, txdone_evt, tx_gate}, 10'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", {status_rdata, txdone_evt, tx_gate}, 10'h000);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check($sformatf("R%0d row %0d", TBL[i].rq, i),
            {status_rdata, txdone_evt, tx_gate}, {TBL[i].rd, TBL[i].ev, TBL[i].gt});
    end
    idle();

    // R2: four distinct entries come back newest first
    push(1'b0, 1'b0);
    push(1'b1, 1'b0);
    push(1'b0, 1'b1);
    push(1'b1, 1'b1);
    check("R2 top after fill", {status_rdata, 2'b00}, {8'hC8, 2'b00});
    pop_check(8'h88);
    pop_check(8'hC0);
    pop_check(8'h80);
    pop_check(8'h00);

    // R10: reset while busy
    tx_enable_cmd = 1'b1;
    @(negedge clk);
    idle();
    push(1'b1, 1'b0);
    push(1'b0, 1'b1);
    check("R10 pre-reset state", {status_rdata, txdone_evt, tx_gate}, {8'h88, 1'b1, 1'b1});
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset mid-run", {status_rdata, txdone_evt, tx_gate}, 10'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 empty after reset", {status_rdata, txdone_evt, tx_gate}, 10'h000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule